// File: doc/BRIEF.md
# ADC Conversion Sequencing Controller

This block drives an external successive-approximation converter through a start/done/data handshake. Software programs one control byte that picks a channel, single-channel or four-channel ordering, one-shot or continuous operation, and an interrupt enable. Each write of that byte cancels any sequence in flight and starts a new four-conversion sequence. Four result registers receive the converted samples in slot order.

In single-channel mode the selected channel is sampled four times. In four-channel mode the top bit of the channel field picks the lower or upper group of four inputs, and that group is converted in ascending order. The completion flag in the same byte rises only when the fourth result of a sequence has been stored. In continuous mode the controller loops without a pause, so the results keep refreshing while the flag stays set. The interrupt line mirrors the flag when it is enabled.

The converter is assumed to abandon any conversion in progress when it sees a new start pulse.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the control/status byte reads 0x00, `conv_start` is low, `irq` is low and all result registers read 0x00.
- R2: Address 0 reads {flag[7], 0[6], one_shot[5], single[4], irq_en[3], chan[2:0]}. The flag reads 0 while a sequence is incomplete and 1 once a full four-slot sequence has been stored.
- R3: With single = 1, every conversion of a sequence uses channel `chan`, and slots 0..3 store the four samples in order.
- R4: With single = 0, the conversions use channels {chan[2], 2'b00} through {chan[2], 2'b11} in ascending order, stored in slots 0..3.
- R5: With one_shot = 1, no further `conv_start` is issued after a sequence completes until the next control write.
- R6: With one_shot = 0, a new sequence begins right after each one completes, the flag stays 1, and the result registers keep updating.
- R7: A write to address 0 clears the flag, abandons the current sequence, and raises `conv_start` for slot 0 in the cycle after the write. A `conv_done` that arrives in the same cycle as the write is discarded.
- R8: `conv_start` is a one-cycle pulse with `conv_ch` valid. No new start is issued until `conv_done` is seen, and `conv_data` is stored on the cycle `conv_done` is high. A `conv_done` is ignored unless a conversion is awaited.
- R9: `irq` is high exactly when the flag is 1 and irq_en is 1.
- R10: Addresses 4..7 read result slots 0..3 and ignore writes. Addresses 1..3 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from address) |
| conv_start | output | 1 | One-cycle conversion start pulse |
| conv_ch | output | 3 | Channel for the conversion being started |
| conv_done | input | 1 | Converter reports a finished conversion |
| conv_data | input | 8 | Conversion result, valid with `conv_done` |
| irq | output | 1 | Interrupt request |

## Verification
A wrong slot index or group select shows up on the very next `conv_start` as a wrong `conv_ch`. The bench checks the channel of every start pulse against the mode, so such an error is caught within one conversion. A wrong slot counter or a lost `conv_done` shows up at the end of the sequence, as a flag that rises one conversion early or late and as results stored in the wrong slots. A stuck sequencer state shows up within a few cycles of a control write, either as a missing start pulse or as starts continuing after a one-shot sequence.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int DATA_W = 8;
  localparam int CH_W   = 3;
  localparam int SLOTS  = 4;
  localparam int ADDR_W = 3;

  // control byte bit positions (software-visible layout)
  localparam int B_FLAG    = 7;
  localparam int B_ONESHOT = 5;
  localparam int B_SINGLE  = 4;
  localparam int B_IE      = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int CH_W  = adc_seq_pkg::CH_W,
  parameter int SLOTS = adc_seq_pkg::SLOTS
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       restart,
  input  logic                       oneshot,
  input  logic                       single,
  input  logic [CH_W-1:0]            ch_sel,
  input  logic                       conv_done,
  output logic                       conv_start,
  output logic [CH_W-1:0]            conv_ch,
  output logic                       res_we,
  output logic [$clog2(SLOTS)-1:0]   res_idx,
  output logic                       seq_end
);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  seq_state_e        state_q, state_d;
  logic [SLOT_W-1:0] idx_q, idx_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    res_we  = 1'b0;
    seq_end = 1'b0;
    if (restart) begin
      state_d = ST_ISSUE;
      idx_d   = '0;
    end else begin
      case (state_q)
        ST_ISSUE: state_d = ST_WAIT;
        ST_WAIT: begin
          if (conv_done) begin
            res_we = 1'b1;
            if (idx_q == LAST) begin
              seq_end = 1'b1;
              idx_d   = '0;
              state_d = oneshot ? ST_IDLE : ST_ISSUE;
            end else begin
              idx_d   = idx_q + 1'b1;
              state_d = ST_ISSUE;
            end
          end
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign conv_start = (state_q == ST_ISSUE);
  assign conv_ch    = single ? ch_sel : {ch_sel[CH_W-1:SLOT_W], idx_q};
  assign res_idx    = idx_q;

  // R8
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && !restart) |=> !conv_start);

  // R8
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !conv_done && !restart) |=> !conv_start);

  // R5
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_end && oneshot && !restart) |=> !conv_start);
endmodule

// File: rtl/adc_seq_results.sv
module adc_seq_results #(
  parameter int DATA_W = adc_seq_pkg::DATA_W,
  parameter int SLOTS  = adc_seq_pkg::SLOTS
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [$clog2(SLOTS)-1:0]   idx,
  input  logic [DATA_W-1:0]          din,
  output logic [SLOTS*DATA_W-1:0]    q_flat
);
  localparam int SLOT_W = $clog2(SLOTS);

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic             en;
    logic [DATA_W-1:0] q;
    assign en = we && (idx == SLOT_W'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= din;
    end
    assign q_flat[k*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = adc_seq_pkg::DATA_W,
  parameter int CH_W   = adc_seq_pkg::CH_W,
  parameter int ADDR_W = adc_seq_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_ch,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              irq
);
  localparam int SLOT_W = $clog2(SLOTS);

  logic            oneshot_q, single_q, ie_q, flag_q, flag_d;
  logic [CH_W-1:0] ch_q;
  logic            wr_ctrl, res_we, seq_end;
  logic [SLOT_W-1:0]       res_idx;
  logic [SLOTS*DATA_W-1:0] res_flat;
  logic [DATA_W-1:0]       res_sel;
  logic [7:0]              status;
  logic                    unused_wbits;

  assign wr_ctrl      = bus_wr && (bus_addr == '0);
  assign unused_wbits = ^bus_wdata[7:6];

  always_comb begin
    flag_d = flag_q;
    if (wr_ctrl)      flag_d = 1'b0;
    else if (seq_end) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oneshot_q <= 1'b0;
      single_q  <= 1'b0;
      ie_q      <= 1'b0;
      ch_q      <= '0;
      flag_q    <= 1'b0;
    end else begin
      flag_q <= flag_d;
      if (wr_ctrl) begin
        oneshot_q <= bus_wdata[B_ONESHOT];
        single_q  <= bus_wdata[B_SINGLE];
        ie_q      <= bus_wdata[B_IE];
        ch_q      <= bus_wdata[CH_W-1:0];
      end
    end
  end

  adc_seq_fsm #(.CH_W(CH_W), .SLOTS(SLOTS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .restart(wr_ctrl),
    .oneshot(oneshot_q), .single(single_q), .ch_sel(ch_q),
    .conv_done(conv_done), .conv_start(conv_start), .conv_ch(conv_ch),
    .res_we(res_we), .res_idx(res_idx), .seq_end(seq_end)
  );

  adc_seq_results #(.DATA_W(DATA_W), .SLOTS(SLOTS)) u_res (
    .clk(clk), .rst_n(rst_n), .we(res_we), .idx(res_idx),
    .din(conv_data), .q_flat(res_flat)
  );

  always_comb begin
    status           = '0;
    status[B_FLAG]   = flag_q;
    status[B_ONESHOT] = oneshot_q;
    status[B_SINGLE] = single_q;
    status[B_IE]     = ie_q;
    status[CH_W-1:0] = ch_q;
    res_sel = res_flat[bus_addr[SLOT_W-1:0]*DATA_W +: DATA_W];
    if (bus_addr[ADDR_W-1])     bus_rdata = 8'(res_sel);
    else if (bus_addr == '0)    bus_rdata = status;
    else                        bus_rdata = '0;
  end

  assign irq = flag_q && ie_q;

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> !flag_q);

  // R2
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(conv_done));
endmodule

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       conv_start, irq;
  logic [2:0] conv_ch;
  logic       conv_done;
  logic [7:0] conv_data;

  always #2 clk = ~clk;

  adc_seq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_start(conv_start),
    .conv_ch(conv_ch), .conv_done(conv_done), .conv_data(conv_data), .irq(irq)
  );

  int n_chk = 0, n_bad = 0, ch_chk = 0, ch_bad = 0, start_cnt = 0;
  int lat_max = 4;
  logic       busy;
  int         cnt;
  logic [1:0] slot_cnt, pend_slot;
  logic [7:0] model_res [4];
  logic       m_single;
  logic [2:0] m_ch;

  function automatic logic [2:0] exp_ch(logic sg, logic [2:0] ch, logic [1:0] slot);
    return sg ? ch : {ch[2], slot};
  endfunction

  // converter model: restarts on every start, answers after 1..lat_max cycles
  always @(posedge clk) begin
    conv_done <= 1'b0;
    if (!rst_n) begin
      busy <= 1'b0; slot_cnt <= '0; pend_slot <= '0; cnt <= 0;
      conv_data <= '0; m_single <= 1'b0; m_ch <= '0;
      for (int k = 0; k < 4; k++) model_res[k] <= '0;
    end else if (bus_wr && bus_addr == 3'd0) begin
      busy <= 1'b0; slot_cnt <= '0;
      m_single <= bus_wdata[4]; m_ch <= bus_wdata[2:0];
    end else begin
      if (conv_done) model_res[pend_slot] <= conv_data;
      if (conv_start) begin
        start_cnt++;
        ch_chk++;
        if (conv_ch !== exp_ch(m_single, m_ch, slot_cnt)) begin
          ch_bad++;
          $display("FAIL R3/R4 channel: actual %0d expected %0d", conv_ch,
                   exp_ch(m_single, m_ch, slot_cnt));
        end
        pend_slot <= slot_cnt;
        slot_cnt  <= slot_cnt + 2'd1;
        busy      <= 1'b1;
        cnt       <= $urandom_range(lat_max, 1);
      end else if (busy) begin
        if (cnt <= 1) begin
          conv_done <= 1'b1;
          conv_data <= 8'($urandom);
          busy      <= 1'b0;
        end else cnt <= cnt - 1;
      end
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic cfg(input logic os, input logic sg, input logic ie, input logic [2:0] ch);
    logic [7:0] v;
    wr(3'd0, {2'b00, os, sg, ie, ch});
    chk("R7 start after write", conv_start, 1'b1);
    rd(3'd0, v);
    chk("R7 flag cleared", v[7], 1'b0);
  endtask

  task automatic wait_flag(input string r);
    logic [7:0] v;
    bit got = 0;
    for (int i = 0; i < 3000 && !got; i++) begin
      @(negedge clk);
      rd(3'd0, v);
      got = v[7];
    end
    chk(r, got, 1'b1);
  endtask

  task automatic check_results(input string r);
    logic [7:0] v;
    for (int k = 0; k < 4; k++) begin
      rd(3'(4 + k), v);
      chk(r, v, model_res[k]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk + ch_chk, n_bad + ch_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int sc;
    void'($urandom(32'h5eed));
    repeat (4) @(negedge clk);
    // R1 reset state
    rd(3'd0, v); chk("R1 status", v, 8'h00);
    chk("R1 start", conv_start, 1'b0);
    chk("R1 irq", irq, 1'b0);
    rd(3'd4, v); chk("R1 result", v, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 unused addresses and read-only results
    rd(3'd1, v); chk("R10 addr1", v, 8'h00);
    wr(3'd5, 8'hAA);
    rd(3'd5, v); chk("R10 result write ignored", v, 8'h00);
    chk("R10 no start from result write", conv_start, 1'b0);

    // R3 single-channel one-shot, irq on
    cfg(1'b1, 1'b1, 1'b1, 3'd5);
    wait_flag("R2 flag after one-shot single");
    rd(3'd0, v); chk("R2 status layout", v, 8'hBD);
    check_results("R3 single results");
    chk("R9 irq enabled", irq, 1'b1);
    sc = start_cnt;
    repeat (40) @(negedge clk);
    chk("R5 no starts after one-shot", start_cnt, sc);
    wr(3'd6, 8'h55);
    check_results("R10 results after write");

    // R4 four-channel upper and lower group, irq off
    cfg(1'b1, 1'b0, 1'b0, 3'd6);
    wait_flag("R2 flag four-channel");
    check_results("R4 upper group");
    chk("R9 irq disabled", irq, 1'b0);
    cfg(1'b1, 1'b0, 1'b1, 3'd1);
    wait_flag("R2 flag lower group");
    check_results("R4 lower group");

    // R6 continuous
    cfg(1'b0, 1'b1, 1'b0, 3'd2);
    wait_flag("R6 flag after first sequence");
    sc = start_cnt;
    repeat (60) @(negedge clk);
    chk("R6 restarts", start_cnt > sc, 1'b1);
    rd(3'd0, v); chk("R6 flag stays", v[7], 1'b1);
    check_results("R6 results refresh");

    // R7 abort mid-sequence
    cfg(1'b1, 1'b0, 1'b0, 3'd3);
    repeat (5) @(negedge clk);
    cfg(1'b1, 1'b0, 1'b0, 3'd7);
    wait_flag("R7 flag after abort");
    check_results("R7 results after abort");

    // random configurations, some aborted midway
    for (int it = 0; it < 30; it++) begin
      logic os, sg, ie;
      logic [2:0] ch;
      lat_max = $urandom_range(8, 1);
      os = 1'($urandom); sg = 1'($urandom); ie = 1'($urandom); ch = 3'($urandom);
      if ($urandom_range(3, 0) == 0) begin
        cfg(1'($urandom), 1'($urandom), 1'b0, 3'($urandom));
        repeat ($urandom_range(12, 1)) @(negedge clk);
      end
      cfg(os, sg, ie, ch);
      wait_flag("R2 random flag");
      check_results(sg ? "R3 random" : "R4 random");
      chk("R9 random irq", irq, ie);
      if (!os) begin
        repeat ($urandom_range(40, 5)) @(negedge clk);
        check_results("R6 random continuous");
      end
    end
    cfg(1'b1, 1'b1, 1'b0, 3'd0);
    wait_flag("R5 final");
    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk + ch_chk, n_bad + ch_bad);
    $finish;
  end
endmodule